// File: doc/BRIEF.md
# Supervisory reset and watchdog generator

This block produces the processor reset of a chip from two causes. The first is an undervoltage flag from an external supply comparator. The flag arrives already filtered and synchronised. The second is a watchdog that expects the software to toggle a service input. If the service input stays quiet for too long, the watchdog forces a reset pulse. Every reset, whatever its cause, is held for a fixed hold time after the cause has gone. The block drives an active-low reset and a separate active-high copy of it.

All timing comes from a free-running prescaler. The prescaler turns the clock into a one-millisecond tick. The tick rate, the watchdog timeout and the hold time are parameters, so a simulation can use short periods. The watchdog cannot be turned off. It stays cleared for as long as reset is asserted, and it starts counting again only when reset is released. The service input is asynchronous. It passes through a two-flop synchroniser, and an edge of either polarity then restarts the watchdog window.

Top module: `sup_reset_gen`

## Requirements
- R1: `rst_o` is always the logical inverse of `rst_no`. Both are registered outputs.
- R2: While `rst_ni` is low, `rst_no` is 0 and `rst_o` is 1. After `rst_ni` is released, reset stays asserted for (HOLD_MS+1)*TICKS_PER_MS cycles, within one cycle, and is then released. This start behaves as if an undervoltage had just ended.
- R3: When `uv_i` is sampled high at a clock edge, `rst_no` is 0 after that edge. It stays 0 for as long as `uv_i` stays high.
- R4: After the last edge at which `uv_i` was sampled high, reset stays asserted for more than HOLD_MS*TICKS_PER_MS cycles and for at most (HOLD_MS+1)*TICKS_PER_MS cycles. Each new high level on `uv_i` restarts the hold count from zero.
- R5: After reset is released, if the synchronised `wdi_i` shows no edge, reset is asserted again exactly WDOG_MS*TICKS_PER_MS cycles after the release.
- R6: `wdi_i` passes through two synchronising flops and then an edge detector. Both a rising and a falling edge clear the watchdog count. Toggling `wdi_i` at intervals shorter than the timeout therefore prevents a watchdog reset, even when the interval between two edges of the same polarity exceeds the timeout.
- R7: The watchdog count is held at zero throughout a reset pulse. Activity on `wdi_i` during reset has no effect on the timing. Each release starts a full timeout window.
- R8: A reset caused by the watchdog lasts exactly (HOLD_MS+1)*TICKS_PER_MS cycles. With `wdi_i` held constant, reset pulses therefore repeat with a period of (WDOG_MS+HOLD_MS+1)*TICKS_PER_MS cycles.
- R9: The prescaler issues one tick every TICKS_PER_MS cycles and runs freely from the release of `rst_ni`. Reset is released only at a tick, and the hold and watchdog counts advance only on ticks. Both counts saturate instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low initialisation |
| uv_i | input | 1 | Synchronised undervoltage flag, active high |
| wdi_i | input | 1 | Asynchronous watchdog service input, either edge services |
| rst_no | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |

## Verification
The hardest case to reach from the ports is the proof that both edge polarities service the watchdog. The bench toggles `wdi_i` at an interval shorter than the timeout, while twice that interval exceeds the timeout. Only a design that clears on both edges then survives the whole stretch without a reset.

A second hard case is the restart of the hold count. A second undervoltage pulse is placed inside the hold window, and the bench checks that the low time of the reset is measured from the second pulse and not from the first.

The clearing of the watchdog during reset needs its own stimulus. The bench toggles `wdi_i` during a watchdog reset pulse and then requires the next high period to be exactly one full timeout.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } sup_state_e;

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/sup_prescaler.sv
module sup_prescaler #(
  parameter int TICKS = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICKS <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(TICKS);
      localparam logic [PW-1:0] LAST = PW'(TICKS - 1);
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sup_edge_sync.sv
module sup_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic edge_o
);
  // sh[STAGES-1:0] synchroniser, sh[STAGES] history for edge detect
  logic [STAGES:0] sh_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end
  assign edge_o = sh_q[STAGES-1] ^ sh_q[STAGES];
endmodule

// File: rtl/sup_sat_counter.sv
module sup_sat_counter #(
  parameter int MAX = 200,
  parameter int W   = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX_V = W'(MAX);
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (inc_i && cnt_q != MAX_V) cnt_q <= cnt_q + 1'b1;
  end
  assign cnt_o = cnt_q;
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
  import sup_pkg::*;
#(
  parameter int TICKS_PER_MS = 50000,
  parameter int WDOG_MS      = 1600,
  parameter int HOLD_MS      = 200,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_i,
  input  logic wdi_i,
  output logic rst_no,
  output logic rst_o
);
  localparam int MAXC  = (WDOG_MS > HOLD_MS) ? WDOG_MS : HOLD_MS;
  localparam int CNT_W = cnt_width(MAXC);
  localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLD_MS);
  localparam logic [CNT_W-1:0] WDOG_LIM = CNT_W'(WDOG_MS - 1);

  logic             tick;
  logic             wdi_edge;
  logic [CNT_W-1:0] hold_cnt;
  logic [CNT_W-1:0] wd_cnt;
  sup_state_e       state_q, state_d;
  logic             in_hold, wd_fire, hold_done;

  sup_prescaler #(.TICKS(TICKS_PER_MS)) i_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  sup_edge_sync #(.STAGES(SYNC_STAGES)) i_wdi_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(wdi_i),
    .edge_o (wdi_edge)
  );

  assign in_hold   = (state_q == ST_HOLD);
  assign wd_fire   = !in_hold && tick && !wdi_edge && (wd_cnt == WDOG_LIM);
  assign hold_done = in_hold && tick && !uv_i && (hold_cnt == HOLD_LIM);

  sup_sat_counter #(.MAX(HOLD_MS), .W(CNT_W)) i_hold_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (uv_i || wd_fire),
    .inc_i (in_hold && tick),
    .cnt_o (hold_cnt)
  );

  sup_sat_counter #(.MAX(WDOG_MS), .W(CNT_W)) i_wd_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (in_hold || wdi_edge),
    .inc_i (tick),
    .cnt_o (wd_cnt)
  );

  always_comb begin
    state_d = state_q;
    if (uv_i)           state_d = ST_HOLD;
    else if (wd_fire)   state_d = ST_HOLD;
    else if (hold_done) state_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HOLD;
    else         state_q <= state_d;
  end

  // separate output flops for the two polarities
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_no <= 1'b0;
    else         rst_no <= (state_d == ST_RUN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_o <= 1'b1;
    else         rst_o <= (state_d == ST_HOLD);
  end
endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
  parameter int WDOG_MS = 1600,
  parameter int HOLD_MS = 200,
  parameter int CNT_W   = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             uv_i,
  input logic             rst_no,
  input logic             rst_o,
  input logic             tick,
  input logic             wdi_edge,
  input logic [CNT_W-1:0] hold_cnt,
  input logic [CNT_W-1:0] wd_cnt
);
  assert_outputs_inverse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o == !rst_no);

  assert_uv_asserts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> !rst_no);

  assert_hold_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_cnt <= CNT_W'(HOLD_MS));

  assert_wd_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rst_no) && !$past(uv_i)) |-> ($past(wd_cnt) == CNT_W'(WDOG_MS - 1)));

  assert_edge_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdi_edge |=> (wd_cnt == '0));

  assert_wd_cleared_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o && $past(rst_o)) |-> (wd_cnt == '0));

  assert_release_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(tick && !uv_i));

  assert_wd_saturates_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_cnt <= CNT_W'(WDOG_MS));
endmodule

bind sup_reset_gen sup_reset_gen_chk #(
  .WDOG_MS(WDOG_MS),
  .HOLD_MS(HOLD_MS),
  .CNT_W  (CNT_W)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .uv_i    (uv_i),
  .rst_no  (rst_no),
  .rst_o   (rst_o),
  .tick    (tick),
  .wdi_edge(wdi_edge),
  .hold_cnt(hold_cnt),
  .wd_cnt  (wd_cnt)
);

// File: tb/test_sup_reset_gen.sv
module test_sup_reset_gen;
  localparam int TPM  = 4;
  localparam int WDOG = 20;
  localparam int HOLD = 5;
  localparam int WD_HIGH  = WDOG * TPM;
  localparam int WD_LOW   = (HOLD + 1) * TPM;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_ni, uv, wdi;
  logic rst_no, rst_o;

  always #2.5 clk = ~clk;

  sup_reset_gen #(
    .TICKS_PER_MS(TPM),
    .WDOG_MS     (WDOG),
    .HOLD_MS     (HOLD)
  ) i_sup_reset_gen (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .uv_i  (uv),
    .wdi_i (wdi),
    .rst_no(rst_no),
    .rst_o (rst_o)
  );

  typedef struct {
    logic  lvl;
    int    lo;
    int    hi;
    string req;
  } seg_t;

  seg_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  int   r1_bad = 0;
  bit   done   = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int lo, input int hi);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic expect_seg(input logic lvl, input int lo, input int hi, input string req);
    seg_t s;
    s.lvl = lvl; s.lo = lo; s.hi = hi; s.req = req;
    exp_q.push_back(s);
  endtask

  task automatic wait_level(input logic lvl);
    do @(negedge clk); while (rst_no !== lvl);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // monitor: measures every reset level segment and pops the scoreboard
  initial begin
    logic prev;
    int   len;
    bit   first;
    seg_t e;
    first = 1'b1;
    len = 0;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_ni === 1'b1) begin
        if (rst_o !== ~rst_no) r1_bad++;
        if (first) begin
          prev = rst_no; len = 1; first = 1'b0;
        end else if (rst_no === prev) begin
          len++;
        end else begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R1", "unexpected segment", len, 0, 0);
          end else begin
            e = exp_q.pop_front();
            check(prev === e.lvl, e.req, "segment level", int'(prev), int'(e.lvl), int'(e.lvl));
            check(len >= e.lo && len <= e.hi, e.req, "segment length", len, e.lo, e.hi);
          end
          prev = rst_no;
          len = 1;
        end
      end
    end
  end

  // driver
  initial begin
    rst_ni = 1'b0; uv = 1'b0; wdi = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(rst_no === 1'b0, "R2", "rst_no during init", int'(rst_no), 0, 0);
    check(rst_o === 1'b1, "R2", "rst_o during init", int'(rst_o), 1, 1);
    expect_seg(1'b0, WD_LOW - 1, WD_LOW + 1, "R2");
    expect_seg(1'b1, WD_HIGH, WD_HIGH, "R5 R9");
    expect_seg(1'b0, WD_LOW, WD_LOW, "R8 R9");
    @(posedge clk);
    #2 rst_ni = 1'b1;

    wait_level(1'b1);
    wait_level(1'b0);
    // R6: toggle every 50 cycles, both edges must service
    expect_seg(1'b1, 575, 590, "R6");
    wait_level(1'b1);
    for (int k = 0; k < 10; k++) begin
      repeat (50) @(negedge clk);
      wdi = ~wdi;
    end
    // R7: activity during the reset pulse has no effect
    expect_seg(1'b0, WD_LOW, WD_LOW, "R7");
    expect_seg(1'b1, WD_HIGH, WD_HIGH, "R7");
    expect_seg(1'b0, WD_LOW, WD_LOW, "R8");
    wait_level(1'b0);
    repeat (4) @(negedge clk);
    wdi = ~wdi;
    repeat (6) @(negedge clk);
    wdi = ~wdi;
    wait_level(1'b1);
    wait_level(1'b0);

    // R3/R4: single undervoltage pulse
    expect_seg(1'b1, 29, 32, "R3");
    expect_seg(1'b0, 28, 35, "R4");
    wait_level(1'b1);
    repeat (30) @(negedge clk);
    uv = 1'b1;
    @(negedge clk);
    check(rst_no === 1'b0, "R3", "rst_no after uv edge", int'(rst_no), 0, 0);
    repeat (9) @(negedge clk);
    check(rst_no === 1'b0 && rst_o === 1'b1, "R3", "reset held while uv", int'(rst_no), 0, 0);
    uv = 1'b0;

    // R4: second pulse inside the hold restarts it
    expect_seg(1'b1, 29, 32, "R3");
    expect_seg(1'b0, 41, 48, "R4");
    expect_seg(1'b1, WD_HIGH, WD_HIGH, "R5");
    wait_level(1'b1);
    repeat (30) @(negedge clk);
    uv = 1'b1;
    repeat (10) @(negedge clk);
    uv = 1'b0;
    repeat (10) @(negedge clk);
    uv = 1'b1;
    repeat (3) @(negedge clk);
    uv = 1'b0;
    wait_level(1'b1);
    wait_level(1'b0);
    repeat (2) @(negedge clk);

    check(exp_q.size() == 0, "R5", "segments left unseen", exp_q.size(), 0, 0);
    check(r1_bad == 0, "R1", "cycles with outputs not inverse", r1_bad, 0, 0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      check(1'b0, "R1", "watchdog expired", 0, 1, 1);
      finish_run();
    end
  end
endmodule